// File: doc/BRIEF.md
# Per-Set MRU-Bit Replacement Selector

This block holds the replacement state for a set-associative cache. Every set owns one "recently used" bit per way. When the cache reports a hit or a fill on a way, the block marks that way as used. When it is asked for a victim in a set, it returns the lowest-numbered way that is not marked.

If marking a way would leave every way in the set marked, the block clears the whole set and then marks only the way that was just accessed. Because of this rule, each set always has at least one unmarked way.

A victim query is answered combinationally from the stored bits. An access takes effect on the next clock edge. An optional mask of invalid ways can override the selection, so that an empty way is filled before a used one is evicted. Tags, data storage and the valid bits themselves belong to the surrounding cache.

Top module: `mru_replace_ctrl`

## Requirements
- R1: After reset every bit in every set is clear, so a query on any set returns way 0.
- R2: An access (`acc_valid` high at a rising edge) marks way `acc_way` of set `acc_set`. From the following cycle on, queries see that mark.
- R3: If marking would leave all ways of the set marked, the set instead holds only the accessed way marked (one-hot at `acc_way`). No set ever holds all bits marked.
- R4: With no invalid way flagged, `vic_way` is the lowest-numbered way of set `qry_set` whose bit is clear.
- R5: When an access and a query name the same set in the same cycle, the query result reflects the bits from before that access.
- R6: An access changes only the bits of the set it names. Other sets are left unaffected.
- R7: When `inv_mask` (bit i means way i is invalid) has any bit set during a query, `vic_way` is the lowest way flagged in `inv_mask`. This takes precedence over the bit-based choice.
- R8: `vic_valid` equals `qry_valid`, because a victim always exists. While `qry_valid` is low, `vic_way` is 0.
- R9: Accessing a way that is already marked leaves the set's bits unchanged.
- R10: With `acc_valid` low, the values on `acc_set` and `acc_way` have no effect on the stored bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe (hit or fill on a way) |
| acc_set | input | SET_W | Set index of the access |
| acc_way | input | WAY_W | Way number of the access |
| qry_valid | input | 1 | Victim query strobe |
| qry_set | input | SET_W | Set index of the query |
| inv_mask | input | NUM_WAYS | Invalid-way flags for the queried set |
| vic_way | output | WAY_W | Selected victim way |
| vic_valid | output | 1 | Victim result is valid |

## Verification
The bit update and the victim query can land on the same set in the same cycle. The bench provokes this by raising the access strobe and the query together on one set. It then samples the victim before the clock edge and expects the pre-update choice. After the edge it expects the post-update choice. A second collision occurs when the access that saturates the set meets a later query. Here the bench expects the set to collapse to a single mark, so the victim returns to way 0.

// File: rtl/plru_pkg.sv
package plru_pkg;
   // Index width that never collapses to zero bits for a count of one.
   function automatic int idx_width(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

   function automatic bit is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction
endpackage

// File: rtl/lowest_one_pick.sv
module lowest_one_pick #(
   parameter int WIDTH = 8,
   localparam int IDX_W = plru_pkg::idx_width(WIDTH)
) (
   input  logic [WIDTH-1:0] vec,
   output logic             found,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      found = |vec;
      idx   = '0;
      for (int i = WIDTH - 1; i >= 0; i--) begin
         if (vec[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/mru_row_store.sv
module mru_row_store #(
   parameter int SETS = 16,
   parameter int WAYS = 8,
   localparam int SET_W = plru_pkg::idx_width(SETS),
   localparam int WAY_W = plru_pkg::idx_width(WAYS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [SET_W-1:0] wr_set,
   input  logic [WAY_W-1:0] wr_way,
   input  logic [SET_W-1:0] rd_set,
   output logic [WAYS-1:0]  rd_bits
);
   logic [WAYS-1:0] rows [SETS];
   logic [WAYS-1:0] way_hot;
   logic [WAYS-1:0] merged;
   logic [WAYS-1:0] next_row;

   always_comb begin
      way_hot  = '0;
      way_hot[wr_way] = 1'b1;
      merged   = rows[wr_set] | way_hot;
      next_row = (&merged) ? way_hot : merged;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) rows[s] <= '0;
      end else if (wr_en) begin
         rows[wr_set] <= next_row;
      end
   end

   assign rd_bits = rows[rd_set];

   // R2: the accessed way is marked after the edge
   assert_mark_after_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> rows[$past(wr_set)][$past(wr_way)]);

   // R10: idle cycles leave the addressed row untouched
   assert_idle_no_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(rows[$past(wr_set)]));

   generate
      for (genvar g = 0; g < SETS; g++) begin : g_row_chk
         // R3: a row never saturates
         assert_row_not_full_R3: assert property (@(posedge clk) disable iff (!rst_n)
            !(&rows[g]));
      end
   endgenerate
endmodule

// File: rtl/mru_replace_ctrl.sv
module mru_replace_ctrl #(
   parameter int NUM_SETS        = 16,
   parameter int NUM_WAYS        = 8,
   parameter bit USE_INVALID_HINT = 1'b1,
   localparam int SET_W = plru_pkg::idx_width(NUM_SETS),
   localparam int WAY_W = plru_pkg::idx_width(NUM_WAYS)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                acc_valid,
   input  logic [SET_W-1:0]    acc_set,
   input  logic [WAY_W-1:0]    acc_way,
   input  logic                qry_valid,
   input  logic [SET_W-1:0]    qry_set,
   input  logic [NUM_WAYS-1:0] inv_mask,
   output logic [WAY_W-1:0]    vic_way,
   output logic                vic_valid
);
   generate
      if (NUM_WAYS < 2 || !plru_pkg::is_pow2(NUM_WAYS)) begin : g_bad_ways
         $error("NUM_WAYS must be a power of two, at least 2");
      end
      if (!plru_pkg::is_pow2(NUM_SETS)) begin : g_bad_sets
         $error("NUM_SETS must be a power of two");
      end
   endgenerate

   logic [NUM_WAYS-1:0] row_bits;
   logic                lru_found;
   logic [WAY_W-1:0]    lru_idx;
   logic                inv_found;
   logic [WAY_W-1:0]    inv_idx;
   logic [WAY_W-1:0]    pick;

   mru_row_store #(.SETS(NUM_SETS), .WAYS(NUM_WAYS)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (acc_valid),
      .wr_set  (acc_set),
      .wr_way  (acc_way),
      .rd_set  (qry_set),
      .rd_bits (row_bits)
   );

   lowest_one_pick #(.WIDTH(NUM_WAYS)) u_zero_pick (
      .vec   (~row_bits),
      .found (lru_found),
      .idx   (lru_idx)
   );

   generate
      if (USE_INVALID_HINT) begin : g_hint
         lowest_one_pick #(.WIDTH(NUM_WAYS)) u_inv_pick (
            .vec   (inv_mask),
            .found (inv_found),
            .idx   (inv_idx)
         );
         assign pick = inv_found ? inv_idx : lru_idx;
      end else begin : g_no_hint
         assign inv_found = 1'b0;
         assign inv_idx   = '0;
         assign pick      = lru_idx;
      end
   endgenerate

   assign vic_valid = qry_valid & (lru_found | inv_found);
   assign vic_way   = qry_valid ? pick : '0;

   // R8: a victim always exists
   assert_valid_tracks_query_R8: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid == qry_valid);

   // R4: without invalid hints the chosen way is unmarked
   assert_victim_unmarked_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (qry_valid && !(|inv_mask)) |-> !row_bits[vic_way]);

   // R7: an invalid way wins when one is flagged
   assert_invalid_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (USE_INVALID_HINT && qry_valid && (|inv_mask)) |-> inv_mask[vic_way]);
endmodule

// File: tb/tb_mru_replace_ctrl.sv
module tb_mru_replace_ctrl;
   localparam int SETS = 16;
   localparam int WAYS = 8;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       acc_valid;
   logic [3:0] acc_set;
   logic [2:0] acc_way;
   logic       qry_valid;
   logic [3:0] qry_set;
   logic [7:0] inv_mask;
   logic [2:0] vic_way;
   logic       vic_valid;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;
   int cyc   = 0;

   always #2.5 clk = ~clk;

   mru_replace_ctrl #(.NUM_SETS(SETS), .NUM_WAYS(WAYS)) dut (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_set(acc_set),
      .acc_way(acc_way), .qry_valid(qry_valid), .qry_set(qry_set),
      .inv_mask(inv_mask), .vic_way(vic_way), .vic_valid(vic_valid)
   );

   // {accessed way, expected victim in set 3 afterwards}
   localparam logic [5:0] VEC [11] = '{
      {3'd0, 3'd1}, {3'd2, 3'd1}, {3'd1, 3'd3}, {3'd1, 3'd3},
      {3'd4, 3'd3}, {3'd3, 3'd5}, {3'd7, 3'd5}, {3'd5, 3'd6},
      {3'd6, 3'd0}, {3'd0, 3'd1}, {3'd6, 3'd1}
   };

   task automatic check(input string req, input logic [2:0] exp_way, input logic exp_v);
      total++;
      if (vic_way !== exp_way || vic_valid !== exp_v) begin
         bad++;
         $display("FAIL %s: way=%0d valid=%0b expected way=%0d valid=%0b",
                  req, vic_way, vic_valid, exp_way, exp_v);
      end
   endtask

   task automatic access(input logic [3:0] s, input logic [2:0] w);
      @(negedge clk);
      acc_valid = 1'b1; acc_set = s; acc_way = w;
      @(negedge clk);
      acc_valid = 1'b0;
   endtask

   task automatic query(input logic [3:0] s);
      qry_valid = 1'b1; qry_set = s; #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 5000 && !done) begin
         total++; bad++;
         $display("FAIL watchdog: cycles=%0d expected below 5000", cyc);
         finish_run();
      end
   end

   initial begin
      rst_n = 1'b0; acc_valid = 1'b0; acc_set = '0; acc_way = '0;
      qry_valid = 1'b0; qry_set = '0; inv_mask = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R8: no query -> not valid, way 0
      #1 check("R8 idle", 3'd0, 1'b0);
      // R1: every set starts at way 0
      query(4'd0);  check("R1 set0", 3'd0, 1'b1);
      query(4'd5);  check("R1 set5", 3'd0, 1'b1);
      query(4'd15); check("R1 set15", 3'd0, 1'b1);

      // Table walk on set 3 (R2, R3, R4, R9)
      for (int i = 0; i < 11; i++) begin
         access(4'd3, VEC[i][5:3]);
         query(4'd3);
         check($sformatf("R2/R3/R4/R9 step %0d", i), VEC[i][2:0], 1'b1);
      end

      // R6: neighbour set untouched
      query(4'd4); check("R6 set4", 3'd0, 1'b1);

      // R10: inputs wiggle with strobe low
      @(negedge clk);
      acc_valid = 1'b0; acc_set = 4'd3; acc_way = 3'd1;
      @(negedge clk);
      query(4'd3); check("R10 idle strobe", 3'd1, 1'b1);

      // R5: same-cycle access and query on set 4
      @(negedge clk);
      acc_valid = 1'b1; acc_set = 4'd4; acc_way = 3'd0;
      query(4'd4); check("R5 pre-update", 3'd0, 1'b1);
      @(negedge clk);
      acc_valid = 1'b0;
      #1 check("R5 post-update", 3'd1, 1'b1);

      // R7: invalid hint overrides
      inv_mask = 8'b0010_0100;
      query(4'd3); check("R7 hint", 3'd2, 1'b1);
      inv_mask = 8'b1000_0000;
      query(4'd3); check("R7 hint high", 3'd7, 1'b1);
      inv_mask = '0;
      query(4'd3); check("R7 no hint", 3'd1, 1'b1);

      // R3: saturate set 9 in ascending order
      for (int w = 0; w < 7; w++) access(4'd9, 3'(w));
      query(4'd9); check("R3 last free", 3'd7, 1'b1);
      access(4'd9, 3'd7);
      query(4'd9); check("R3 collapse", 3'd0, 1'b1);

      qry_valid = 1'b0; #1;
      check("R8 drop", 3'd0, 1'b0);
      finish_run();
   end
endmodule